// File: doc/BRIEF.md
# Conversion Word-Rate Timer

This block holds the 24-bit control word of a sigma-delta converter and derives from it the timing of finished output words. A word is finished every `512 × CODE` oscillator cycles, where CODE is the 11-bit filter code held in the control word. The oscillator rate comes in as a clock enable, `osc_en`, on the system clock. Each finished word is marked by a one-cycle `word_ready` pulse.

The filter needs between three and four word periods to settle after a step. The block therefore tracks settling after every change to the filter code or the gain code. Such a change restarts the word-period count and drops `settled`. The flag comes back with the fourth `word_ready` pulse after the restart.

The host writes and reads the control word through a plain parallel port. A write takes effect on the clock edge where `wr_en` is high. `rd_data` always shows the stored word. There is no streaming path, so no handshake is used.

Top module: `decim_rate_timer`

## Requirements
- R1: The control word layout is: coding bit at bit 23, filter code at bits 22:12, operating mode at bits 11:9, bipolar select at bit 8, gain code at bits 7:5, and further held bits at 4:0. After reset the word is 24'h00A300: coding 0, code 10, mode 3'b001, bipolar 1, gain 3'b000, low bits 0.
- R2: A write with `wr_en` high stores `wr_data` into the control word on that clock edge. `rd_data` shows the stored word from the next cycle on.
- R3: A written filter code below 10 is stored as 10. Codes from 10 to 2047 are stored as written. A restart is decided on the code after this clamping.
- R4: With `osc_en` held high, `word_ready` pulses high for exactly one cycle every `512 × CODE` cycles. The first pulse comes `512 × CODE` cycles after reset or after a restarting write.
- R5: Only cycles with `osc_en` high advance the word period. With `osc_en` low, no pulse is produced.
- R6: A write that changes the stored filter code or the gain code restarts the period count and clears `settled` on the same edge.
- R7: A write that leaves both the filter code and the gain code unchanged does not restart the count and does not clear `settled`.
- R8: `settled` is low after reset. It rises on the same cycle as the fourth `word_ready` pulse after reset or after a restart, and it stays high until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | Oscillator-rate clock enable |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 24 | Control word to write |
| rd_data | output | 24 | Stored control word |
| word_ready | output | 1 | One-cycle pulse at the end of each word period |
| settled | output | 1 | Current word is fully settled |

## Verification
The bench measures word periods to the exact cycle, both from a restart and between pulses. An off-by-one in the period compare therefore shows up as a period of 5119 or 5121 instead of 5120.

A write that leaves the code and gain unchanged must leave the period running. The next pulse then arrives one cycle short of a full period, so a design that restarts on every write would give a full period instead. A write of a code below 10, made while the code is already 10, must neither restart the count nor store the raw value. A design that compared before clamping would restart the count there.

The bench counts pulses to catch a settle flag raised on the third or fifth word. It also gates the enable on alternate cycles and expects the period to double; a design that ignored `osc_en` would keep the ungated period.

// File: rtl/decim_rate_timer_pkg.sv
package decim_rate_timer_pkg;
  localparam int CTRL_W = 24;
  localparam int CODE_W = 11;

  // Field order is the bit layout of the control word, MSB first.
  typedef struct packed {
    logic              coding;
    logic [CODE_W-1:0] code;
    logic [2:0]        mode;
    logic              bipolar;
    logic [2:0]        gain;
    logic [4:0]        aux;
  } ctrl_t;

  localparam logic [2:0] MODE_SELF_CAL = 3'b001;
endpackage

// File: rtl/drt_ctrl_reg.sv
module drt_ctrl_reg
  import decim_rate_timer_pkg::*;
#(
  parameter int CODE_MIN = 10,
  parameter int RST_CODE = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wr_word,
  output ctrl_t ctrl,
  output logic  restart
);
  localparam logic [CODE_W-1:0] MIN_C = CODE_W'(CODE_MIN);
  localparam ctrl_t RST_WORD = '{coding: 1'b0, code: CODE_W'(RST_CODE),
                                 mode: MODE_SELF_CAL, bipolar: 1'b1,
                                 gain: 3'b000, aux: 5'd0};

  ctrl_t ctrl_q, wr_fix;

  always_comb begin
    wr_fix = wr_word;
    if (wr_word.code < MIN_C) wr_fix.code = MIN_C;
    restart = wr_en && ((wr_fix.code != ctrl_q.code) || (wr_fix.gain != ctrl_q.gain));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= RST_WORD;
    else if (wr_en) ctrl_q <= wr_fix;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/drt_period_gen.sv
module drt_period_gen #(
  parameter int CODE_W  = 11,
  parameter int SUB_DIV = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick,
  output logic              word_ready
);
  localparam int CNT_W = CODE_W + $clog2(SUB_DIV);

  logic [CNT_W-1:0] cnt, limit;

  assign limit = CNT_W'(code) * CNT_W'(SUB_DIV) - CNT_W'(1);
  assign tick  = osc_en && !restart && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt        <= '0;
      word_ready <= 1'b0;
    end else begin
      word_ready <= tick;
      if (osc_en) cnt <= (cnt == limit) ? '0 : cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/drt_settle_track.sv
module drt_settle_track #(
  parameter int WORDS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic settled
);
  localparam int SW = $clog2(WORDS + 1);

  logic [SW-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      seen    <= '0;
      settled <= 1'b0;
    end else if (tick && !settled) begin
      seen <= seen + SW'(1);
      if (seen == SW'(WORDS - 1)) settled <= 1'b1;
    end
  end
endmodule

// File: rtl/decim_rate_timer.sv
module decim_rate_timer
  import decim_rate_timer_pkg::*;
#(
  parameter int CODE_MIN     = 10,
  parameter int RST_CODE     = 10,
  parameter int SUB_DIV      = 512,
  parameter int SETTLE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              word_ready,
  output logic              settled
);
  ctrl_t ctrl;
  logic  restart, tick;

  drt_ctrl_reg #(.CODE_MIN(CODE_MIN), .RST_CODE(RST_CODE)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(ctrl_t'(wr_data)),
    .ctrl(ctrl), .restart(restart));

  drt_period_gen #(.CODE_W(CODE_W), .SUB_DIV(SUB_DIV)) u_period (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .restart(restart),
    .code(ctrl.code), .tick(tick), .word_ready(word_ready));

  drt_settle_track #(.WORDS(SETTLE_WORDS)) u_settle (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .settled(settled));

  assign rd_data = ctrl;
endmodule

// File: rtl/decim_rate_timer_chk.sv
module decim_rate_timer_chk #(
  parameter int CODE_MIN = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        osc_en,
  input logic        wr_en,
  input logic [23:0] wr_data,
  input logic [23:0] rd_data,
  input logic        word_ready,
  input logic        settled
);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |=> !word_ready);

  a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> $past(osc_en));

  a_r3_code_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[22:12] >= 11'(CODE_MIN));

  a_r8_rise_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> word_ready);

  a_r6_gain_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[7:5] != rd_data[7:5])) |=> (!settled && !word_ready));

  a_r7_keep_settled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && settled && (wr_data[22:12] == rd_data[22:12]) &&
     (wr_data[7:5] == rd_data[7:5])) |=> settled);
endmodule

bind decim_rate_timer decim_rate_timer_chk #(.CODE_MIN(CODE_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .word_ready(word_ready),
  .settled(settled));

// File: tb/decim_rate_timer_test.sv
module decim_rate_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SUB       = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_en = 1'b1;
  logic        wr_en = 1'b0;
  logic [23:0] wr_data = '0;
  logic [23:0] rd_data;
  logic        word_ready, settled;

  int n_chk = 0;
  int n_bad = 0;

  decim_rate_timer uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .word_ready(word_ready),
    .settled(settled));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] mk(input logic dc, input int code,
      input logic [2:0] md, input logic bu, input logic [2:0] g, input logic [4:0] ax);
    return {dc, 11'(code), md, bu, g, ax};
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [23:0] w);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Counts negedges until word_ready is seen; optional alternate-cycle enable.
  task automatic measure(input bit gate, output int k);
    k = 0;
    if (gate) osc_en = 1'b0;
    while (1) begin
      @(negedge clk);
      k++;
      if (word_ready || k > 40000) break;
      if (gate) osc_en = k[0];
    end
    osc_en = 1'b1;
  endtask

  task automatic t_reset;
    chk(rd_data, 24'h00A300, "R1 reset word");
    chk(word_ready, 0, "R4 no pulse in reset");
    chk(settled, 0, "R8 settled low after reset");
  endtask

  task automatic t_settle_from_reset;
    int k;
    rst_n = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      measure(0, k);
      chk(k, 10*SUB, "R4 period code 10");
      chk(settled, (i == 4) ? 1 : 0, "R8 settled at fourth pulse");
    end
    @(negedge clk);
    chk(word_ready, 0, "R4 pulse one cycle");
    chk(settled, 1, "R8 settled holds");
  endtask

  task automatic t_other_fields;
    int k;
    logic [23:0] w;
    w = mk(1'b1, 10, 3'b100, 1'b0, 3'b000, 5'h15);
    measure(0, k);
    wr(w);
    chk(rd_data, w, "R2 readback");
    chk(settled, 1, "R7 settled kept");
    measure(0, k);
    chk(k, 10*SUB - 1, "R7 no restart");
    chk(settled, 1, "R7 settled kept at pulse");
  endtask

  task automatic t_gain_change;
    int k;
    wr(mk(1'b1, 10, 3'b100, 1'b0, 3'b011, 5'h15));
    chk(settled, 0, "R6 settled cleared");
    measure(0, k);
    chk(k, 10*SUB, "R6 restart full period");
    chk(settled, 0, "R6 settled low first pulse");
  endtask

  task automatic t_code12;
    int k;
    wr(mk(1'b0, 12, 3'b001, 1'b1, 3'b011, 5'h0));
    chk(rd_data[22:12], 12, "R2 code field");
    measure(0, k);
    chk(k, 12*SUB, "R4 period code 12");
    measure(0, k);
    chk(k, 12*SUB, "R4 steady period code 12");
  endtask

  task automatic t_clamp;
    int k;
    wr(mk(1'b0, 3, 3'b001, 1'b1, 3'b011, 5'h0));
    chk(rd_data[22:12], 10, "R3 clamp to 10");
    measure(0, k);
    chk(k, 10*SUB, "R3 clamped period");
    wr(mk(1'b0, 0, 3'b001, 1'b1, 3'b011, 5'h0));
    chk(rd_data[22:12], 10, "R3 zero clamps");
    measure(0, k);
    chk(k, 10*SUB - 1, "R3 clamped equal code no restart");
    wr(mk(1'b0, 2047, 3'b001, 1'b1, 3'b011, 5'h0));
    chk(rd_data[22:12], 2047, "R3 top code kept");
  endtask

  task automatic t_gate;
    int k;
    wr(mk(1'b0, 10, 3'b001, 1'b1, 3'b000, 5'h0));
    measure(1, k);
    chk(k, 20*SUB, "R5 gated period doubles");
    osc_en = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (word_ready) k = -1;
    end
    chk(k, 20*SUB, "R5 no pulse while disabled");
    osc_en = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_settle_from_reset();
    t_other_fields();
    t_gain_change();
    t_code12();
    t_clamp();
    t_gate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule